// File: doc/BRIEF.md
# Configuration Context Store with Single-Cycle Array Distribution

This block holds configuration context words for an 8 by 8 array of processing cells and loads the per-cell context registers from that store. Context words sit in a banked store of 4 blocks. Each block holds 8 sets, and each set holds 8 words of 32 bits. A controller fills the store one word at a time through a write port. The cells keep running on the contexts they already hold, so preparing the next context costs no array time.

A distribute command names a block, a set, one of four modes and a target index. In one clock cycle it copies the eight words of that set into the cell context registers. The two broadcast modes copy words across whole rows or whole columns. The two selective modes load only one row or one column, each cell with a different word, and leave every other cell as it was. A done pulse follows each command by one cycle. The 64 context registers leave the block on one flat output bus.

Top module: `cfg_ctx_distributor`

## Requirements
- R1: Every word of every block and set is stored independently. The storage address is block (0..3), set (0..7) and word (0..7), and any stored word can later be distributed unchanged.
- R2: Mode code 0 is the row broadcast. Every cell in row r takes word r of the named set, whatever the target index is.
- R3: Mode code 1 is the column broadcast. Every cell in column c takes word c of the named set, whatever the target index is.
- R4: Mode code 2 is the selective row load. The cell at row = index, column i takes word i of the set. Every cell in the other rows keeps its value.
- R5: Mode code 3 is the selective column load. The cell at row i, column = index takes word i of the set. Every cell in the other columns keeps its value.
- R6: A write to the store never changes any cell context register. Only a distribute command changes them.
- R7: The cell registers take their new values on the clock edge that samples the command. The done output is high for exactly the one cycle after each command, and is low otherwise.
- R8: If a write and a distribute touch the same set in the same cycle, the distribute uses the contents from before the write. A later distribute sees the new word.
- R9: Reset clears all 64 cell context registers and the stored words to zero, and drives done low.
- R10: The context of cell (row r, column c) appears on `cell_ctx[(r*8+c)*32 +: 32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store write strobe |
| wr_blk | input | 2 | Block written |
| wr_set | input | 3 | Set written |
| wr_word | input | 3 | Word position written |
| wr_data | input | 32 | Context word to store |
| dist_en | input | 1 | Distribute command strobe |
| dist_blk | input | 2 | Source block |
| dist_set | input | 3 | Source set |
| dist_mode | input | 2 | 0 row broadcast, 1 column broadcast, 2 selective row, 3 selective column |
| dist_idx | input | 3 | Target row or column for the selective modes |
| dist_done | output | 1 | One-cycle pulse after each command |
| cell_ctx | output | 2048 | All cell context registers, packed as in R10 |

## Verification
A cell whose select logic is wrong takes the wrong word or the wrong neighbour's word. This shows on its own 32-bit slice of `cell_ctx` in the cycle right after the command. A load enable that fires outside the target row or column damages a cell that should have held its value. A stored word at the wrong address only shows when its set is next distributed. For that reason every set of every block is broadcast once, and the bench compares the whole 2048-bit image after each command. Same-cycle write and distribute pairs show whether the read happens before the write.

// File: rtl/ctxd_pkg.sv
package ctxd_pkg;

   typedef enum logic [1:0] {
      MODE_ROW_BC  = 2'd0,
      MODE_COL_BC  = 2'd1,
      MODE_SEL_ROW = 2'd2,
      MODE_SEL_COL = 2'd3
   } dist_mode_e;

endpackage

// File: rtl/ctxd_store.sv
module ctxd_store #(
   parameter int BLOCKS      = 4,
   parameter int SETS        = 8,
   parameter int WORDS       = 8,
   parameter int W           = 32,
   parameter bit RESET_STORE = 1'b1,
   localparam int BW = $clog2(BLOCKS),
   localparam int SW = $clog2(SETS),
   localparam int WW = $clog2(WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [BW-1:0]      wr_blk,
   input  logic [SW-1:0]      wr_set,
   input  logic [WW-1:0]      wr_word,
   input  logic [W-1:0]       wr_data,
   input  logic [BW-1:0]      rd_blk,
   input  logic [SW-1:0]      rd_set,
   output logic [WORDS*W-1:0] rd_words
);
   localparam int DEPTH = BLOCKS * SETS * WORDS;
   localparam int AW    = BW + SW + WW;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_addr;
   logic [AW-1:0] rd_base;

   assign wr_addr = {wr_blk, wr_set, wr_word};
   assign rd_base = {rd_blk, rd_set, {WW{1'b0}}};

   generate
      if (RESET_STORE) begin : g_rst_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_plain_store
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_addr] <= wr_data;
         end
      end
   endgenerate

   always_comb begin
      for (int w = 0; w < WORDS; w++) begin
         rd_words[w*W +: W] = mem[rd_base | AW'(w)];
      end
   end

endmodule

// File: rtl/ctxd_route.sv
module ctxd_route
   import ctxd_pkg::*;
#(
   parameter int DIM = 8,
   localparam int IW    = $clog2(DIM),
   localparam int CELLS = DIM * DIM
) (
   input  logic            go,
   input  dist_mode_e      mode,
   input  logic [IW-1:0]   idx,
   output logic [CELLS-1:0] ld_en,
   output logic [CELLS*IW-1:0] sel
);
   for (genvar r = 0; r < DIM; r++) begin : g_row
      for (genvar c = 0; c < DIM; c++) begin : g_col
         localparam int K = r * DIM + c;
         logic in_row, in_col;
         assign in_row = (idx == IW'(r));
         assign in_col = (idx == IW'(c));
         always_comb begin
            unique case (mode)
               MODE_ROW_BC: begin
                  ld_en[K]          = go;
                  sel[K*IW +: IW]   = IW'(r);
               end
               MODE_COL_BC: begin
                  ld_en[K]          = go;
                  sel[K*IW +: IW]   = IW'(c);
               end
               MODE_SEL_ROW: begin
                  ld_en[K]          = go & in_row;
                  sel[K*IW +: IW]   = IW'(c);
               end
               default: begin
                  ld_en[K]          = go & in_col;
                  sel[K*IW +: IW]   = IW'(r);
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/ctxd_cell_bank.sv
module ctxd_cell_bank #(
   parameter int DIM = 8,
   parameter int W   = 32,
   localparam int IW    = $clog2(DIM),
   localparam int CELLS = DIM * DIM
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIM*W-1:0]    set_words,
   input  logic [CELLS-1:0]    ld_en,
   input  logic [CELLS*IW-1:0] sel,
   output logic [CELLS*W-1:0]  cell_ctx
);
   logic [W-1:0] words_a [DIM];

   for (genvar w = 0; w < DIM; w++) begin : g_unpack
      assign words_a[w] = set_words[w*W +: W];
   end

   for (genvar k = 0; k < CELLS; k++) begin : g_cell
      logic [W-1:0] q;
      logic [W-1:0] pick;
      assign pick = words_a[sel[k*IW +: IW]];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= '0;
         else if (ld_en[k]) q <= pick;
      end
      assign cell_ctx[k*W +: W] = q;
   end

endmodule

// File: rtl/cfg_ctx_distributor.sv
module cfg_ctx_distributor
   import ctxd_pkg::*;
#(
   parameter int BLOCKS      = 4,
   parameter int SETS        = 8,
   parameter int DIM         = 8,
   parameter int W           = 32,
   parameter bit RESET_STORE = 1'b1,
   localparam int BW    = $clog2(BLOCKS),
   localparam int SW    = $clog2(SETS),
   localparam int IW    = $clog2(DIM),
   localparam int CELLS = DIM * DIM
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [BW-1:0]      wr_blk,
   input  logic [SW-1:0]      wr_set,
   input  logic [IW-1:0]      wr_word,
   input  logic [W-1:0]       wr_data,
   input  logic               dist_en,
   input  logic [BW-1:0]      dist_blk,
   input  logic [SW-1:0]      dist_set,
   input  logic [1:0]         dist_mode,
   input  logic [IW-1:0]      dist_idx,
   output logic               dist_done,
   output logic [CELLS*W-1:0] cell_ctx
);
   if (BLOCKS < 1 || (BLOCKS & (BLOCKS - 1)) != 0) begin : g_chk_blocks
      $error("BLOCKS must be a power of two");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_chk_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (DIM < 2 || (DIM & (DIM - 1)) != 0) begin : g_chk_dim
      $error("DIM must be a power of two of at least 2");
   end
   if (W < 1) begin : g_chk_w
      $error("W must be positive");
   end

   logic [DIM*W-1:0]    set_words;
   logic [CELLS-1:0]    ld_en;
   logic [CELLS*IW-1:0] sel;
   logic                done_q;

   ctxd_store #(
      .BLOCKS(BLOCKS), .SETS(SETS), .WORDS(DIM), .W(W), .RESET_STORE(RESET_STORE)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_blk   (wr_blk),
      .wr_set   (wr_set),
      .wr_word  (wr_word),
      .wr_data  (wr_data),
      .rd_blk   (dist_blk),
      .rd_set   (dist_set),
      .rd_words (set_words)
   );

   ctxd_route #(.DIM(DIM)) u_route (
      .go    (dist_en),
      .mode  (dist_mode_e'(dist_mode)),
      .idx   (dist_idx),
      .ld_en (ld_en),
      .sel   (sel)
   );

   ctxd_cell_bank #(.DIM(DIM), .W(W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_words (set_words),
      .ld_en     (ld_en),
      .sel       (sel),
      .cell_ctx  (cell_ctx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= dist_en;
   end
   assign dist_done = done_q;

endmodule

// File: rtl/ctxd_checker.sv
module ctxd_checker #(
   parameter int DIM = 8,
   parameter int W   = 32,
   localparam int IW    = $clog2(DIM),
   localparam int CELLS = DIM * DIM
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dist_en,
   input logic [1:0]         dist_mode,
   input logic [IW-1:0]      dist_idx,
   input logic               dist_done,
   input logic [CELLS*W-1:0] cell_ctx
);
   // R7: done follows every command by one cycle and only then
   a_r7_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      dist_en |=> dist_done);
   a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !dist_en |=> !dist_done);

   // R6: without a command the cell registers hold, writes included
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dist_en |=> $stable(cell_ctx));

   for (genvar r = 0; r < DIM; r++) begin : g_r
      for (genvar c = 0; c < DIM; c++) begin : g_c
         localparam int K  = r * DIM + c;
         localparam int K0 = r * DIM;
         localparam int KC = c;
         // R2: after a row broadcast each row is uniform
         a_r2_row_uniform: assert property (@(posedge clk) disable iff (!rst_n)
            (dist_en && dist_mode == 2'd0) |=> cell_ctx[K*W +: W] == cell_ctx[K0*W +: W]);
         // R3: after a column broadcast each column is uniform
         a_r3_col_uniform: assert property (@(posedge clk) disable iff (!rst_n)
            (dist_en && dist_mode == 2'd1) |=> cell_ctx[K*W +: W] == cell_ctx[KC*W +: W]);
         // R4: a selective row load leaves other rows alone
         a_r4_other_rows_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (dist_en && dist_mode == 2'd2 && dist_idx != IW'(r)) |=> $stable(cell_ctx[K*W +: W]));
         // R5: a selective column load leaves other columns alone
         a_r5_other_cols_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (dist_en && dist_mode == 2'd3 && dist_idx != IW'(c)) |=> $stable(cell_ctx[K*W +: W]));
      end
   end

endmodule

bind cfg_ctx_distributor ctxd_checker #(.DIM(DIM), .W(W)) u_ctxd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .dist_en   (dist_en),
   .dist_mode (dist_mode),
   .dist_idx  (dist_idx),
   .dist_done (dist_done),
   .cell_ctx  (cell_ctx)
);

// File: tb/test_cfg_ctx_distributor.sv
`timescale 1ns/1ps
module test_cfg_ctx_distributor;
   localparam int N  = 8;
   localparam int W  = 32;
   localparam int FW = N * N * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_blk = '0;
   logic [2:0]    wr_set = '0;
   logic [2:0]    wr_word = '0;
   logic [31:0]   wr_data = '0;
   logic          dist_en = 1'b0;
   logic [1:0]    dist_blk = '0;
   logic [2:0]    dist_set = '0;
   logic [1:0]    dist_mode = '0;
   logic [2:0]    dist_idx = '0;
   logic          dist_done;
   logic [FW-1:0] cell_ctx;

   int tests = 0;
   int fails = 0;
   bit done_run = 1'b0;

   logic [31:0]   mdl [4][8][8];
   logic [31:0]   expc [8][8];
   logic [FW-1:0] exp_q [$];
   string         tag_q [$];

   always #4 clk = ~clk;

   cfg_ctx_distributor i_cfg_ctx_distributor (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_blk(wr_blk), .wr_set(wr_set),
      .wr_word(wr_word), .wr_data(wr_data), .dist_en(dist_en), .dist_blk(dist_blk),
      .dist_set(dist_set), .dist_mode(dist_mode), .dist_idx(dist_idx),
      .dist_done(dist_done), .cell_ctx(cell_ctx)
   );

   function automatic logic [31:0] pat(int b, int s, int w, int salt);
      return {4'(b), 4'(s), 4'(w), 4'(salt), 16'((b * 64 + s * 8 + w) * 37) ^ 16'h5A3C};
   endfunction

   // R10: cell (r,c) lives at bits (r*8+c)*32
   function automatic logic [FW-1:0] flat();
      logic [FW-1:0] f;
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            f[(r * N + c) * W +: W] = expc[r][c];
      return f;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [FW-1:0] act,
                        input logic [FW-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle of stimulus; optional write and optional distribute
   task automatic step(input bit we, input int wb, input int ws, input int ww,
                       input logic [31:0] wd, input bit de, input int db, input int ds,
                       input int dm, input int di, input string tag);
      @(negedge clk);
      wr_en = we; wr_blk = 2'(wb); wr_set = 3'(ws); wr_word = 3'(ww); wr_data = wd;
      dist_en = de; dist_blk = 2'(db); dist_set = 3'(ds);
      dist_mode = 2'(dm); dist_idx = 3'(di);
      if (de) begin
         for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
               case (dm)
                  0: expc[r][c] = mdl[db][ds][r];
                  1: expc[r][c] = mdl[db][ds][c];
                  2: if (r == di) expc[r][c] = mdl[db][ds][c];
                  default: if (c == di) expc[r][c] = mdl[db][ds][r];
               endcase
         exp_q.push_back(flat());
         tag_q.push_back(tag);
      end
      if (we) mdl[wb][ws][ww] = wd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, 0, 0, 0, 0, 0, "");
   endtask

   // monitor: compares each done pulse against the scoreboard
   always @(negedge clk) begin
      if (rst_n && dist_done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 done without command", {2047'd0, dist_done}, '0);
         end else begin
            logic [FW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(cell_ctx === e, t, cell_ctx, e);
         end
      end
   end

   initial begin
      for (int b = 0; b < 4; b++)
         for (int s = 0; s < 8; s++)
            for (int w = 0; w < 8; w++) mdl[b][s][w] = '0;
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) expc[r][c] = '0;

      repeat (3) @(negedge clk);
      check(cell_ctx === '0 && dist_done === 1'b0, "R9 reset state", cell_ctx, '0);
      rst_n = 1'b1;

      // R1: fill every word of every set
      for (int b = 0; b < 4; b++)
         for (int s = 0; s < 8; s++)
            for (int w = 0; w < 8; w++)
               step(1, b, s, w, pat(b, s, w, 1), 0, 0, 0, 0, 0, "");
      idle(1);
      // R6: writes alone left all cells at zero
      @(negedge clk);
      check(cell_ctx === '0, "R6 writes do not touch cells", cell_ctx, '0);

      // R1 R2: broadcast every set by rows (index ignored)
      for (int b = 0; b < 4; b++)
         for (int s = 0; s < 8; s++)
            step(0, 0, 0, 0, '0, 1, b, s, 0, (b + s) % 8, "R1 R2 row broadcast of stored set");
      idle(2);

      // R3: column broadcasts, back to back
      step(0, 0, 0, 0, '0, 1, 1, 6, 1, 5, "R3 column broadcast");
      step(0, 0, 0, 0, '0, 1, 3, 2, 1, 0, "R3 column broadcast back to back");
      // R4: selective rows on top
      step(0, 0, 0, 0, '0, 1, 0, 4, 2, 0, "R4 selective row 0");
      step(0, 0, 0, 0, '0, 1, 2, 7, 2, 7, "R4 selective row 7");
      idle(1);
      step(0, 0, 0, 0, '0, 1, 1, 1, 2, 3, "R4 selective row 3");
      // R5: selective columns
      step(0, 0, 0, 0, '0, 1, 3, 5, 3, 0, "R5 selective column 0");
      step(0, 0, 0, 0, '0, 1, 2, 3, 3, 7, "R5 selective column 7");
      step(0, 0, 0, 0, '0, 1, 0, 0, 3, 4, "R5 selective column 4");
      idle(2);

      // R6: rewrite a set while idle; cells must not move
      for (int w = 0; w < 8; w++) step(1, 2, 5, w, pat(2, 5, w, 7), 0, 0, 0, 0, 0, "");
      idle(1);
      @(negedge clk);
      check(cell_ctx === flat(), "R6 cells hold during writes", cell_ctx, flat());

      // R8: same-cycle write and distribute on the same set reads old contents
      step(1, 2, 5, 3, 32'hDEAD_0003, 1, 2, 5, 0, 0, "R8 collision uses old word");
      step(1, 2, 5, 6, 32'hBEEF_0006, 1, 2, 5, 3, 6, "R8 collision selective column");
      step(0, 0, 0, 0, '0, 1, 2, 5, 1, 0, "R8 later distribute sees new words");
      idle(3);

      check(exp_q.size() == 0, "R7 every command produced one done pulse",
            FW'(exp_q.size()), '0);
      done_run = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8ns * 20000);
      if (!done_run) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule